// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers configuration-space reads and writes for a single endpoint function. A requester presents a byte address inside the 4 KB configuration window, a read/write flag, write data and an access-size code. The block decodes the dword and the byte lanes, updates the few writable fields and returns right-aligned read data one cycle after the request is accepted.

The register set has four groups. The identity fields are fixed: vendor, device, class and subclass, and a header type of zero. The 16-bit command register can be written. Six base-address slots follow. Slot 0 is an I/O window of 1 byte and slot 1 is a 32-bit memory window of 256 bytes. Both support size discovery by writing all ones. Slots 2 to 5 are present but always read zero. The last group is a hard-wired chain of standard capability headers (power management, PCI Express, MSI-X) and a chain of extended capability headers (advanced error reporting, virtual channel, serial number).

A small state machine sequences each access. Its states are `ST_IDLE`, `ST_READ` and `ST_WRITE`. It has these transitions:
- `ST_IDLE` to `ST_READ` on an accepted read.
- `ST_IDLE` to `ST_WRITE` on an accepted write.
- `ST_READ` to `ST_IDLE` and `ST_WRITE` to `ST_IDLE` unconditionally, after one response cycle.

Top module: `cfg_space_responder`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. An accepted request (`req_valid && req_ready`) raises `rsp_valid` for exactly the next cycle, and `req_ready` is low during that cycle.
- R2: The dword at address 0x00 reads `{DEVICE_ID, VENDOR_ID}`. The header-type byte at 0x0E reads 0.
- R3: The class field depends on the access size. An 8-bit read at 0x0A returns the subclass. A 16-bit read at 0x0A returns `{class, subclass}`. A 32-bit read at 0x08 returns `{class, subclass, 16'h0}`.
- R4: The command register at 0x04 bits 15:0 stores each written byte lane and reads it back. Bits 31:16 of that dword read 0.
- R5: Slot 0 (0x10) is I/O and bit 0 always reads 1. Slot 1 (0x14) is memory and stores the written value as is. Only the enabled byte lanes change.
- R6: A slot holding all ones reads its size mask instead. For slot 0 that is 0xFFFFFFFD: the size mask under the I/O mask ~3, plus bit 0 = 1. For slot 1 it is 0xFFFFFF00: the size mask under the memory mask ~0xF, with type bits 0.
- R7: Slots 2 to 5 (0x18, 0x1C, 0x20, 0x24) always read 0, and writes to them have no effect.
- R8: The capabilities pointer byte at 0x34 reads 0x40. The header at 0x40 reads 0x5001 (next 0x50, ID 0x01). The header at 0x50 reads 0x7010 (next 0x70, ID 0x10). The header at 0x70 reads 0x0011 (next 0, ID 0x11).
- R9: The extended header at 0x100 reads 0x14000001 (next offset 0x140 at bit 20, ID 1). The header at 0x140 reads 0x18000002. The header at 0x180 reads 0x00000003, so its next field is 0.
- R10: Writes to any address other than the command register and slots 0 and 1 change nothing. Every write response carries data 0.
- R11: A read of an address not listed above returns 0.
- R12: Size code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. `req_addr[1:0]` selects the first byte lane. Read data is shifted right to bit 0 and masked to the size. Lanes that would fall past byte 3 are dropped on both reads and writes.
- R13: After reset the command register is 0, slot 0 reads 0x00000001, slot 1 reads 0, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in configuration space |
| req_size | input | 2 | Access size code (0: 8, 1: 16, 2/3: 32 bits) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, right-aligned; 0 for writes |

## Verification
The hardest situation to reach is the size-discovery read of the I/O slot. The type bit is forced on every write, so an all-ones write is the only way to make the slot hold all ones and switch it to its mask. The bench writes all ones to each slot and checks the mask. It then writes an ordinary base back and checks that the normal value returns with bit 0 intact. Accesses that straddle the end of a dword are also checked: a 32-bit write starting at lane 1 of the command dword, and a 16-bit read at byte 3. Together they show that dropped lanes neither corrupt the register nor leak data.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cfg_state_t;

    localparam logic [31:0] IO_ADDR_MASK  = 32'hFFFF_FFFC;
    localparam logic [31:0] MEM_ADDR_MASK = 32'hFFFF_FFF0;
    localparam logic [31:0] IO_SPACE_BIT  = 32'h0000_0001;
    localparam logic [31:0] MEM_TYPE_32   = 32'h0000_0000;

    localparam logic [7:0]  CAPID_PM      = 8'h01;
    localparam logic [7:0]  CAPID_PCIE    = 8'h10;
    localparam logic [7:0]  CAPID_MSIX    = 8'h11;
    localparam logic [15:0] XCAPID_AER    = 16'h0001;
    localparam logic [15:0] XCAPID_VC     = 16'h0002;
    localparam logic [15:0] XCAPID_SERIAL = 16'h0003;

    function automatic logic [31:0] slot_size_mask(input logic is_io, input logic [31:0] bytes);
        logic [31:0] m;
        m = ~(bytes - 32'd1);
        if (is_io) slot_size_mask = (m & IO_ADDR_MASK) | IO_SPACE_BIT;
        else       slot_size_mask = (m & MEM_ADDR_MASK) | MEM_TYPE_32;
    endfunction

endpackage

// File: rtl/cfg_lane_align.sv
module cfg_lane_align (
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata_in,
    input  logic [31:0] rdata_in,
    output logic [3:0]  be,
    output logic [31:0] wdata_out,
    output logic [31:0] rdata_out
);
    logic [7:0]  be_wide;
    logic [3:0]  be_base;
    logic [31:0] size_mask;
    logic [4:0]  shamt;

    always_comb begin
        unique case (size)
            2'd0:    begin be_base = 4'b0001; size_mask = 32'h0000_00FF; end
            2'd1:    begin be_base = 4'b0011; size_mask = 32'h0000_FFFF; end
            default: begin be_base = 4'b1111; size_mask = 32'hFFFF_FFFF; end
        endcase
        shamt     = {lane, 3'b000};
        be_wide   = {4'b0000, be_base} << lane;
        be        = be_wide[3:0];
        wdata_out = wdata_in << shamt;
        rdata_out = (rdata_in >> shamt) & size_mask;
    end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
    parameter logic        IS_IO = 1'b0,
    parameter logic [31:0] BYTES = 32'd256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    import cfg_pkg::*;

    localparam logic [31:0] RESET_VAL = {31'd0, IS_IO};
    localparam logic [31:0] DISCOVER  = slot_size_mask(IS_IO, BYTES);

    logic [31:0] bar_q;
    logic [31:0] merged;

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : bar_q[b*8 +: 8];
        end
        merged[0] = merged[0] | IS_IO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bar_q <= RESET_VAL;
        else if (wr_en) bar_q <= merged;
    end

    assign rd_data = (bar_q == 32'hFFFF_FFFF) ? DISCOVER : bar_q;

    // R5
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bar_q));

    generate
        if (IS_IO) begin : g_io_chk
            // R5
            io_space_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> bar_q[0]);
        end
    endgenerate
endmodule

// File: rtl/cfg_fixed_rom.sv
module cfg_fixed_rom #(
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h5A01,
    parameter logic [7:0]  CLASS_CODE = 8'h07,
    parameter logic [7:0]  SUBCLASS   = 8'h80,
    parameter logic [7:0]  PM_OFS     = 8'h40,
    parameter logic [7:0]  PCIE_OFS   = 8'h50,
    parameter logic [7:0]  MSIX_OFS   = 8'h70,
    parameter logic [11:0] AER_OFS    = 12'h100,
    parameter logic [11:0] VC_OFS     = 12'h140,
    parameter logic [11:0] SER_OFS    = 12'h180
) (
    input  logic [9:0]  dw_idx,
    output logic [31:0] data
);
    import cfg_pkg::*;

    logic [11:0] byte_addr;
    assign byte_addr = {dw_idx, 2'b00};

    always_comb begin
        data = 32'h0;
        if (byte_addr == 12'h000)
            data = {DEVICE_ID, VENDOR_ID};
        else if (byte_addr == 12'h008)
            data = {CLASS_CODE, SUBCLASS, 16'h0000};
        else if (byte_addr == 12'h034)
            data = {24'h0, PM_OFS};
        else if (byte_addr == {4'h0, PM_OFS})
            data = {16'h0, PCIE_OFS, CAPID_PM};
        else if (byte_addr == {4'h0, PCIE_OFS})
            data = {16'h0, MSIX_OFS, CAPID_PCIE};
        else if (byte_addr == {4'h0, MSIX_OFS})
            data = {16'h0, 8'h00, CAPID_MSIX};
        else if (byte_addr == AER_OFS)
            data = {VC_OFS, 4'h0, XCAPID_AER};
        else if (byte_addr == VC_OFS)
            data = {SER_OFS, 4'h0, XCAPID_VC};
        else if (byte_addr == SER_OFS)
            data = {12'h000, 4'h0, XCAPID_SERIAL};
    end
endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder #(
    parameter int          ADDR_W        = 12,
    parameter int          NUM_SLOTS     = 6,
    parameter logic [31:0] IO_BAR_BYTES  = 32'd1,
    parameter logic [31:0] MEM_BAR_BYTES = 32'd256,
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h5A01,
    parameter logic [7:0]  CLASS_CODE    = 8'h07,
    parameter logic [7:0]  SUBCLASS      = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    import cfg_pkg::*;

    localparam int          IDX_W     = ADDR_W - 2;
    localparam logic [IDX_W-1:0] CMD_IDX  = IDX_W'(1);
    localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(4);

    cfg_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [31:0]       wdata_q;
    logic [15:0]       cmd_q;
    logic              wr_fire;

    logic [IDX_W-1:0]  idx;
    logic [3:0]        be;
    logic [31:0]       wdata_lane;
    logic [31:0]       raw_rd;
    logic [31:0]       aligned_rd;
    logic [31:0]       rom_rd;
    logic [31:0]       slot_rd [NUM_SLOTS];

    assign idx = addr_q[ADDR_W-1:2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        wr_fire   = 1'b0;
        rsp_rdata = 32'h0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  begin rsp_valid = 1'b1; rsp_rdata = aligned_rd; end
            ST_WRITE: begin rsp_valid = 1'b1; wr_fire = 1'b1; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            wdata_q <= req_wdata;
        end
    end

    cfg_lane_align u_align (
        .lane      (addr_q[1:0]),
        .size      (size_q),
        .wdata_in  (wdata_q),
        .rdata_in  (raw_rd),
        .be        (be),
        .wdata_out (wdata_lane),
        .rdata_out (aligned_rd)
    );

    // command register
    logic cmd_we;
    assign cmd_we = wr_fire && (idx == CMD_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_we) begin
            if (be[0]) cmd_q[7:0]  <= wdata_lane[7:0];
            if (be[1]) cmd_q[15:8] <= wdata_lane[15:8];
        end
    end

    // base-address slots
    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            if (i < 2) begin : g_live
                logic slot_we;
                assign slot_we = wr_fire && (idx == SLOT_IDX + IDX_W'(i));
                cfg_bar_slot #(
                    .IS_IO (i == 0),
                    .BYTES ((i == 0) ? IO_BAR_BYTES : MEM_BAR_BYTES)
                ) u_slot (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .wr_en   (slot_we),
                    .wr_be   (be),
                    .wr_data (wdata_lane),
                    .rd_data (slot_rd[i])
                );
            end else begin : g_empty
                assign slot_rd[i] = 32'h0;
            end
        end
    endgenerate

    cfg_fixed_rom #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .CLASS_CODE (CLASS_CODE),
        .SUBCLASS   (SUBCLASS)
    ) u_rom (
        .dw_idx (idx),
        .data   (rom_rd)
    );

    always_comb begin
        raw_rd = rom_rd;
        if (idx == CMD_IDX) raw_rd = {16'h0, cmd_q};
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (idx == SLOT_IDX + IDX_W'(i)) raw_rd = slot_rd[i];
        end
    end

    // R1
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R1
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1
    no_accept_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state_q == ST_WRITE) |-> (rsp_rdata == 32'h0));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q));
endmodule

// File: tb/cfg_space_responder_bench.sv
module cfg_space_responder_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [15:0] VID  = 16'hC0DE;
    localparam logic [15:0] DID  = 16'h5A01;
    localparam logic [7:0]  CLS  = 8'h07;
    localparam logic [7:0]  SUB  = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_space_responder u_cfg_space_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rsp_rdata, e);
            end
        end
    end

    // driver
    task automatic access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        exp_q.push_back(wr ? 32'h0 : exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        access(1'b0, a, sz, 32'h0, exp, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd, input string tag);
        access(1'b1, a, sz, wd, 32'h0, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state at the ports
        check("R13 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
        check("R13 req_ready idle", {31'h0, req_ready}, 32'h1);
        rd(12'h004, 2'd2, 32'h0000_0000, "R13 command reset");
        rd(12'h010, 2'd2, 32'h0000_0001, "R13 slot0 reset");
        rd(12'h014, 2'd2, 32'h0000_0000, "R13 slot1 reset");

        // R2 identity
        rd(12'h000, 2'd2, {DID, VID}, "R2 id dword");
        rd(12'h002, 2'd1, {16'h0, DID}, "R2 device id");
        rd(12'h00E, 2'd0, 32'h0, "R2 header type");

        // R3 class field by size
        rd(12'h00A, 2'd0, {24'h0, SUB}, "R3 class 8-bit");
        rd(12'h00A, 2'd1, {16'h0, CLS, SUB}, "R3 class 16-bit");
        rd(12'h008, 2'd2, {CLS, SUB, 16'h0}, "R3 class 32-bit");

        // R4 command register
        wr(12'h004, 2'd1, 32'h0000_0146, "R4 write cmd");
        rd(12'h004, 2'd2, 32'h0000_0146, "R4 read cmd");
        wr(12'h005, 2'd0, 32'h0000_00AB, "R4 write cmd hi byte");
        rd(12'h004, 2'd1, 32'h0000_AB46, "R4 cmd after byte write");
        rd(12'h005, 2'd0, 32'h0000_00AB, "R4 cmd hi byte");

        // R5 / R6 slot 0
        wr(12'h010, 2'd2, 32'h0000_C000, "R5 slot0 write");
        rd(12'h010, 2'd2, 32'h0000_C001, "R5 slot0 space bit");
        wr(12'h010, 2'd2, 32'hFFFF_FFFF, "R6 slot0 all ones");
        rd(12'h010, 2'd2, 32'hFFFF_FFFD, "R6 slot0 size mask");
        wr(12'h010, 2'd2, 32'h1000_0000, "R5 slot0 rewrite");
        rd(12'h010, 2'd2, 32'h1000_0001, "R5 slot0 after discovery");

        // R5 / R6 slot 1
        wr(12'h014, 2'd2, 32'hFFFF_FFFF, "R6 slot1 all ones");
        rd(12'h014, 2'd2, 32'hFFFF_FF00, "R6 slot1 size mask");
        wr(12'h014, 2'd2, 32'hE000_0000, "R5 slot1 write");
        rd(12'h014, 2'd2, 32'hE000_0000, "R5 slot1 read");
        wr(12'h016, 2'd1, 32'h0000_1234, "R5 slot1 upper half");
        rd(12'h014, 2'd2, 32'h1234_0000, "R5 slot1 lane merge");

        // R7 unimplemented slots
        wr(12'h018, 2'd2, 32'hFFFF_FFFF, "R7 slot2 write");
        rd(12'h018, 2'd2, 32'h0, "R7 slot2 read");
        wr(12'h024, 2'd2, 32'h1234_5678, "R7 slot5 write");
        rd(12'h024, 2'd2, 32'h0, "R7 slot5 read");

        // R8 standard chain
        rd(12'h034, 2'd0, 32'h0000_0040, "R8 cap pointer");
        rd(12'h040, 2'd2, 32'h0000_5001, "R8 pm header");
        rd(12'h050, 2'd2, 32'h0000_7010, "R8 pcie header");
        rd(12'h070, 2'd2, 32'h0000_0011, "R8 msix header");

        // R9 extended chain
        rd(12'h100, 2'd2, 32'h1400_0001, "R9 aer header");
        rd(12'h140, 2'd2, 32'h1800_0002, "R9 vc header");
        rd(12'h180, 2'd2, 32'h0000_0003, "R9 serial header");

        // R10 ignored writes
        wr(12'h000, 2'd2, 32'hFFFF_FFFF, "R10 write id");
        rd(12'h000, 2'd2, {DID, VID}, "R10 id unchanged");
        wr(12'h100, 2'd2, 32'h0, "R10 write ext header");
        rd(12'h100, 2'd2, 32'h1400_0001, "R10 ext unchanged");
        wr(12'h006, 2'd1, 32'h0000_FFFF, "R10 write status half");
        rd(12'h004, 2'd2, 32'h0000_AB46, "R10 status stays zero");

        // R11 unlisted
        rd(12'h200, 2'd2, 32'h0, "R11 unlisted 0x200");
        rd(12'h03C, 2'd2, 32'h0, "R11 unlisted 0x03C");

        // R12 lane handling
        wr(12'h005, 2'd2, 32'hFFFF_FF5C, "R12 straddling write");
        rd(12'h004, 2'd2, 32'h0000_5C46, "R12 straddle kept lanes");
        rd(12'h003, 2'd1, {16'h0, 8'h00, DID[15:8]}, "R12 straddling read");
        rd(12'h000, 2'd3, {DID, VID}, "R12 size code 3");
        rd(12'h001, 2'd0, {24'h0, VID[15:8]}, "R12 byte lane 1");

        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule